// File: doc/BRIEF.md
# I2S Master Transmitter with Bit-Clock Divider

This block sends stereo audio as an I2S master. It runs from a master clock and divides that clock by a programmable ratio to make the bit clock. It drives both the bit clock and the word-select line, and shifts serial data out most-significant bit first in standard I2S framing. Each frame has a left slot followed by a right slot. Each slot lasts one bit clock per bit of the programmed resolution. Only the low-order resolution bits of each 32-bit word are sent.

Audio comes from a FIFO as a left/right word pair with a valid flag. The block pops one pair at the start of every frame except the first frame after enable, which is always silent. If no pair is waiting when a frame starts, that frame carries zeros and nothing is popped. When enable drops, the frame in progress runs to its end. The bit clock, word select and data then rest low. The ratio and the resolution are sampled at each frame start.

Top module: `i2s_master_tx`

## Requirements
- R1: After reset, and while enable has never been raised, `bclk`, `ws`, `sd` and `fifo_pop` are all 0 and `bclk` does not toggle.
- R2: Each high phase and each low phase of `bclk` lasts exactly `ratio`+2 master-clock cycles, where `ratio` is 8 bits wide. The bit clock is therefore MCLK/(2·(ratio+2)).
- R3: A frame is 2·N bit clocks long, where N is the effective resolution. The left slot comes first, then the right slot. `ws` is 0 while the left slot is sampled and 1 while the right slot is sampled. `ws` switches one bit clock before the MSB of each slot, and it changes only on a falling edge of `bclk`.
- R4: Within each slot, `sd` carries bits N-1 down to 0 of that slot's 32-bit word, MSB first, one bit per bit clock. Bits above N are never sent. `sd` changes only on a falling edge of `bclk`, so it is stable at every rising edge.
- R5: The first frame after enable rises from idle carries all-zero data in both slots, starts with the left slot, and pops nothing.
- R6: At the start of every later frame, if `fifo_valid` is 1, one pair is taken and `fifo_pop` pulses for exactly one master-clock cycle. If `fifo_valid` is 0, that frame sends zeros and `fifo_pop` stays 0.
- R7: When `enable` is dropped, the current frame completes, so the total number of bit clocks is a whole number of frames. After that, `bclk`, `sd` and `ws` stay at 0.
- R8: A resolution value outside 2..32 (0, 1 or 33..63) is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start transmission; when it drops, the current frame finishes |
| ratio | input | 8 | Divider setting; each bit-clock half period is ratio+2 master-clock cycles |
| resolution | input | 6 | Bits per slot, 2..32 (other values mean 32) |
| fifo_left | input | 32 | Left word at the FIFO head |
| fifo_right | input | 32 | Right word at the FIFO head |
| fifo_valid | input | 1 | A pair is available at the FIFO head |
| fifo_pop | output | 1 | One-cycle strobe that takes the head pair |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select: 0 for left, 1 for right |
| sd | output | 1 | Serial data, MSB first |

## Verification
A sweep steps the resolution through every value from 2 to 32, with the ratio cycling through 0..3, and decodes every bit clock. This shows whether the slot length, the MSB position and the WS lead all track the resolution, and whether unused high bits stay out of the stream. Separate runs use the largest divider, out-of-range resolutions, and a FIFO that runs dry before enable drops. These runs show the difference between a silent start frame, an underrun frame and a data frame, and they check that the pop count follows the frames that actually carried data. Each run drops enable in the middle of a slot, so the bit-clock count shows whether the closing frame was cut short or allowed to complete.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    parameter int WORD_W  = 32;
    parameter int RATIO_W = 8;
    parameter int RES_W   = 6;

    localparam int HALF_W  = RATIO_W + 1;
    localparam int POS_W   = RES_W + 1;
    localparam int MIN_RES = 2;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pair_t;

    typedef enum logic {ST_IDLE, ST_RUN} tx_state_t;

    // Out-of-range resolution codes fall back to the full word.
    function automatic logic [RES_W-1:0] eff_res(input logic [RES_W-1:0] r);
        if (r < RES_W'(MIN_RES) || r > RES_W'(WORD_W))
            return RES_W'(WORD_W);
        return r;
    endfunction

    // Word select for a bit position: it leads the slot by one bit clock.
    function automatic logic ws_at(input logic [POS_W-1:0] p, input logic [RES_W-1:0] r);
        logic [POS_W-1:0] last;
        logic [POS_W-1:0] nxt;
        last = {r, 1'b0} - 1'b1;
        nxt  = (p == last) ? '0 : p + 1'b1;
        return nxt >= {1'b0, r};
    endfunction

    // Serial bit for a position in the frame, MSB of the low r bits first.
    function automatic logic bit_at(input pair_t w, input logic [POS_W-1:0] p,
                                    input logic [RES_W-1:0] r);
        logic [POS_W-1:0] idx;
        if (p < {1'b0, r}) begin
            idx = {1'b0, r} - 1'b1 - p;
            return 1'(w.left >> idx);
        end
        idx = {r, 1'b0} - 1'b1 - p;
        return 1'(w.right >> idx);
    endfunction
endpackage

// File: rtl/i2s_tx_bclk_div.sv
module i2s_tx_bclk_div
    import i2s_tx_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] half_len,
    output logic          bclk,
    output logic          fall_evt
);
    logic [HW-1:0] cnt;
    logic          term;

    assign term     = (cnt == half_len - 1'b1);
    assign fall_evt = run && term && bclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (term) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R2: the phase counter never passes the programmed half period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt < half_len);
endmodule

// File: rtl/i2s_tx_frame_seq.sv
module i2s_tx_frame_seq
    import i2s_tx_pkg::*;
#(
    parameter int RW  = RATIO_W,
    parameter int SW  = RES_W,
    parameter int HW  = HALF_W,
    parameter int PW  = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [RW-1:0] ratio,
    input  logic [SW-1:0] resolution,
    input  pair_t         pair_in,
    input  logic          fifo_valid,
    input  logic          fall_evt,
    output logic          run,
    output logic [HW-1:0] half_len,
    output logic          ws,
    output logic          sd,
    output logic          pop
);
    tx_state_t     state;
    logic [PW-1:0] pos;
    logic [SW-1:0] res_q;
    pair_t         frame_q;

    logic [PW-1:0] last_pos;
    logic [PW-1:0] next_pos;
    logic [SW-1:0] res_new;
    logic [HW-1:0] half_new;
    pair_t         load_pair;

    assign run       = (state == ST_RUN);
    assign last_pos  = {res_q, 1'b0} - 1'b1;
    assign next_pos  = pos + 1'b1;
    assign res_new   = eff_res(resolution);
    assign half_new  = HW'(ratio) + HW'(2);
    assign load_pair = fifo_valid ? pair_in : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pos      <= '0;
            res_q    <= SW'(WORD_W);
            half_len <= HW'(2);
            frame_q  <= '0;
            ws       <= 1'b0;
            sd       <= 1'b0;
            pop      <= 1'b0;
        end else begin
            pop <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (enable) begin
                        // silent lead-in frame, left slot first
                        state    <= ST_RUN;
                        pos      <= '0;
                        res_q    <= res_new;
                        half_len <= half_new;
                        frame_q  <= '0;
                        ws       <= ws_at('0, res_new);
                        sd       <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (fall_evt) begin
                        if (pos == last_pos) begin
                            if (!enable) begin
                                state   <= ST_IDLE;
                                pos     <= '0;
                                frame_q <= '0;
                                ws      <= 1'b0;
                                sd      <= 1'b0;
                            end else begin
                                pos      <= '0;
                                res_q    <= res_new;
                                half_len <= half_new;
                                frame_q  <= load_pair;
                                pop      <= fifo_valid;
                                ws       <= ws_at('0, res_new);
                                sd       <= bit_at(load_pair, '0, res_new);
                            end
                        end else begin
                            pos <= next_pos;
                            ws  <= ws_at(next_pos, res_q);
                            sd  <= bit_at(frame_q, next_pos, res_q);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a pop is a single-cycle strobe
    a_r6_pop_single: assert property (@(posedge clk) disable iff (rst)
        pop |=> !pop);
    // R6: a pop only follows a cycle where the FIFO offered data
    a_r6_pop_valid: assert property (@(posedge clk) disable iff (rst)
        pop |-> $past(fifo_valid));
    // R3: bit position stays inside a 2*N frame
    a_r3_pos_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> pos < {res_q, 1'b0});
endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx
    import i2s_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RES_W-1:0]   resolution,
    input  logic [WORD_W-1:0]  fifo_left,
    input  logic [WORD_W-1:0]  fifo_right,
    input  logic               fifo_valid,
    output logic               fifo_pop,
    output logic               bclk,
    output logic               ws,
    output logic               sd
);
    logic              run;
    logic              fall_evt;
    logic [HALF_W-1:0] half_len;
    pair_t             head;

    assign head = '{left: fifo_left, right: fifo_right};

    i2s_tx_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .ratio      (ratio),
        .resolution (resolution),
        .pair_in    (head),
        .fifo_valid (fifo_valid),
        .fall_evt   (fall_evt),
        .run        (run),
        .half_len   (half_len),
        .ws         (ws),
        .sd         (sd),
        .pop        (fifo_pop)
    );

    i2s_tx_bclk_div u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_len (half_len),
        .bclk     (bclk),
        .fall_evt (fall_evt)
    );

    // R4: data moves only while the bit clock is low
    a_r4_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd) |-> !bclk);
    // R3: word select moves only while the bit clock is low
    a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws) |-> !bclk);
    // R7: leaving the running state leaves every serial line low
    a_r7_stop_low: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> (!bclk && !sd && !ws));
endmodule

// File: tb/i2s_master_tx_tb.sv
`timescale 1ns/1ps
module i2s_master_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [7:0]  ratio_i;
    logic [5:0]  res_i;
    logic [31:0] fl, fr;
    logic        fvalid;
    logic        fifo_pop, bclk, ws, sd;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2s_master_tx dut_i (
        .clk(clk), .rst(rst), .enable(enable), .ratio(ratio_i),
        .resolution(res_i), .fifo_left(fl), .fifo_right(fr),
        .fifo_valid(fvalid), .fifo_pop(fifo_pop), .bclk(bclk),
        .ws(ws), .sd(sd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_l(input int k);
        return 32'h9E3779B9 * 32'(k + 1) ^ 32'h5A0F_C3A1;
    endfunction
    function automatic logic [31:0] word_r(input int k);
        logic [31:0] v;
        v = ~word_l(k + 7);
        return {v[12:0], v[31:13]};
    endfunction

    task automatic run_case(input int rat, input int rs, input int nwords,
                            input int stop_frame);
        int er, h, fb, rises, toggles, since, pops, rd, guard;
        int half_err, ws_err, bit_err, f0_err, exp_pops;
        logic prev;
        er = (rs < 2 || rs > 32) ? 32 : rs;   // R8
        h  = rat + 2;
        fb = 2 * er;
        rises = 0; toggles = 0; since = 0; pops = 0; rd = 0; guard = 0;
        half_err = 0; ws_err = 0; bit_err = 0; f0_err = 0;
        @(negedge clk);
        ratio_i = 8'(rat);
        res_i   = 6'(rs);
        fvalid  = (nwords > 0);
        fl = word_l(0); fr = word_r(0);
        prev = bclk;
        enable = 1'b1;
        forever begin
            @(negedge clk);
            since++;
            guard++;
            if (fifo_pop) begin
                pops++;
                rd++;
                fvalid = (rd < nwords);
                fl = word_l(rd); fr = word_r(rd);
            end
            if (bclk != prev) begin
                if (toggles > 0 && since != h) half_err++;
                toggles++;
                since = 0;
                if (bclk) begin
                    int f, p, n;
                    logic [31:0] el, erw;
                    logic exp_ws, exp_sd;
                    f = rises / fb;
                    p = rises % fb;
                    el  = (f >= 1 && f - 1 < nwords) ? word_l(f - 1) : 32'd0;
                    erw = (f >= 1 && f - 1 < nwords) ? word_r(f - 1) : 32'd0;
                    n = (p + 1) % fb;
                    exp_ws = (n >= er);
                    exp_sd = (p < er) ? el[er - 1 - p] : erw[2 * er - 1 - p];
                    if (ws != exp_ws) ws_err++;
                    if (sd != exp_sd) begin
                        bit_err++;
                        if (f == 0) f0_err++;
                    end
                    rises++;
                    if (f == stop_frame && p == er) enable = 1'b0;
                end
            end
            prev = bclk;
            if (!enable && since > 4 * h + 8) break;
            if (guard > 60000) break;
        end
        exp_pops = (nwords < stop_frame) ? nwords : stop_frame;
        chk(rises == (stop_frame + 1) * fb, "R7", "bit clocks until stop", rises,
            (stop_frame + 1) * fb);
        chk(half_err == 0, "R2", "bclk half periods off", half_err, 0);
        chk(ws_err == 0, "R3", "ws mismatches", ws_err, 0);
        chk(bit_err == 0, (rs < 2 || rs > 32) ? "R8" : "R4", "sd mismatches", bit_err, 0);
        chk(f0_err == 0, "R5", "nonzero bits in lead-in frame", f0_err, 0);
        chk(pops == exp_pops, "R6", "pop count", pops, exp_pops);
        chk(!bclk && !sd && !ws, "R7", "lines after stop", {bclk, sd, ws}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int tog;
        logic pb;
        rst = 1'b1; enable = 1'b0; ratio_i = '0; res_i = 6'd32;
        fl = '0; fr = '0; fvalid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset with enable low, even with data offered
        fvalid = 1'b1; fl = 32'hFFFF_FFFF; fr = 32'hFFFF_FFFF;
        tog = 0; pb = bclk;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (bclk != pb) tog++;
            pb = bclk;
            if (fifo_pop || ws || sd) tog++;
        end
        chk(tog == 0, "R1", "activity while idle", tog, 0);
        chk(!bclk && !ws && !sd && !fifo_pop, "R1", "reset outputs",
            {bclk, ws, sd, fifo_pop}, 0);

        // main sweep: every resolution, ratio cycling 0..3
        for (int r = 2; r <= 32; r++) run_case(r % 4, r, 2, 2);
        // underrun: FIFO dries after one pair, R6 zero frames follow
        run_case(2, 16, 1, 4);
        // FIFO empty from the start
        run_case(0, 32, 0, 2);
        // largest divider
        run_case(255, 2, 1, 1);
        // R8: out-of-range resolutions fall back to 32
        run_case(0, 0, 2, 2);
        run_case(1, 1, 1, 1);
        run_case(0, 40, 2, 2);
        // longer stream
        run_case(1, 24, 6, 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule